// File: doc/BRIEF.md
# Sticky Event Status Register with Masked Interrupts

This block collects single-cycle event pulses from a set of sources into a bank of sticky status bits. A bit stays at 1 once its event has been seen and drops only when the host reads the status word. That one read returns every captured bit and clears them all together. A pulse that lands in the same cycle as the clearing read is not lost. It stays in the bank and is reported by the next read.

Two host-programmable registers sit beside the status bank. The first is a per-bit interrupt mask, with 1 meaning blocked. The status bits keep capturing events whatever the mask holds. The second is a per-source enable that can stop a source from reaching its status bit at all. The block drives two registered, active-low interrupt lines. The host-bus line falls whenever any set status bit is unmasked. The local-bus line does the same, but only while the configuration-mode input is high.

Host access uses a plain strobe interface. A write updates the mask or enable register in the cycle of the strobe. A read returns its data one cycle after the strobe.

Top module: `sir_status_block`

## Requirements
- R1: A pulse on `evt[i]` while enable bit i is 1 sets status bit i. The bit then stays 1 until a status read, whatever the event input does afterwards.
- R2: A read at address 0 returns the status word on `rdata` one cycle after the `rd_en` strobe and clears every status bit. A second read with no new events returns 0.
- R3: An enabled event in the same cycle as a clearing read leaves its status bit at 1 after the read, so the following read reports it.
- R4: Status bits capture events whatever the mask holds. A masked bit still reads back as 1.
- R5: The mask register at address 1 can be read and written. It resets to all ones, and a 1 blocks that bit from the interrupts.
- R6: `irq_host_n` is low exactly when, on the previous clock edge, some status bit was 1 with its mask bit 0. Otherwise it is high.
- R7: `irq_local_n` follows the same rule as R6, gated with `cfg_mode` sampled on that same edge. With `cfg_mode` low it stays high.
- R8: The source-enable register at address 2 can be read and written and resets to all ones. A 0 in bit i stops `evt[i]` from setting status bit i.
- R9: After reset the status word is 0, both interrupt lines are high and `rdata` is 0.
- R10: A write to address 0 is ignored. The status word keeps its captured bits and gains no new ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Local bus is in configuration mode; enables `irq_local_n` |
| evt | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Register select: 0 status, 1 mask, 2 source enable, 3 reads zero |
| wdata | input | NUM_SRC | Host write data |
| rdata | output | NUM_SRC | Registered host read data |
| irq_host_n | output | 1 | Host-bus interrupt, active low, registered |
| irq_local_n | output | 1 | Local-bus interrupt, active low, registered, gated by `cfg_mode` |

## Verification
The bench builds the block with `NUM_SRC = 8`. Every bit of the status, mask and enable words can then be driven and read back through the host port. The bench can set all-ones, single-bit and mixed patterns, and so reach a full word of sticky bits with only part of it unmasked. It also places an event in the exact cycle of a clearing read. Using the same width, it checks that a disabled source and a masked source behave differently: the first never sets its bit, while the second sets its bit but raises no interrupt.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int unsigned SIR_ADDR_W = 2;

  typedef enum logic [SIR_ADDR_W-1:0] {
    SIR_REG_STATUS = 2'd0,
    SIR_REG_MASK   = 2'd1,
    SIR_REG_SRCEN  = 2'd2,
    SIR_REG_NONE   = 2'd3
  } sir_reg_e;
endpackage

// File: rtl/sir_event_capture.sv
module sir_event_capture #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               rd_clr,
  output logic [NUM_SRC-1:0] status_q
);
  logic [NUM_SRC-1:0] evt_gated;
  logic [NUM_SRC-1:0] status_d;

  function automatic logic [NUM_SRC-1:0] f_next_status(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] hits,
    input logic               clr
  );
    logic [NUM_SRC-1:0] kept;
    kept = clr ? '0 : cur;
    return kept | hits;
  endfunction

  always_comb evt_gated = evt & src_en;
  always_comb status_d  = f_next_status(status_q, evt_gated, rd_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R1: without a read, no captured bit drops
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R2: after a read only bits hit in that cycle survive
  assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((status_q & ~$past(evt & src_en)) == '0));

  // R3: an enabled event is never lost, even under a clearing read
  assert_event_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & src_en)) |=> ((status_q & $past(evt & src_en)) == $past(evt & src_en)));

  // R8: a bit only rises when its source fired while enabled
  assert_no_disabled_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt & src_en)) == '0));
endmodule

// File: rtl/sir_host_regs.sv
module sir_host_regs
  import sir_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [SIR_ADDR_W-1:0] addr,
  input  logic [NUM_SRC-1:0]    wdata,
  input  logic [NUM_SRC-1:0]    status_q,
  output logic [NUM_SRC-1:0]    mask_q,
  output logic [NUM_SRC-1:0]    srcen_q,
  output logic                  rd_clr,
  output logic [NUM_SRC-1:0]    rdata_q
);
  logic wr_mask;
  logic wr_srcen;
  logic [NUM_SRC-1:0] rd_mux;

  function automatic logic [NUM_SRC-1:0] f_read_sel(
    input logic [SIR_ADDR_W-1:0] a,
    input logic [NUM_SRC-1:0]    st,
    input logic [NUM_SRC-1:0]    mk,
    input logic [NUM_SRC-1:0]    en
  );
    case (sir_reg_e'(a))
      SIR_REG_STATUS: return st;
      SIR_REG_MASK:   return mk;
      SIR_REG_SRCEN:  return en;
      default:        return '0;
    endcase
  endfunction

  always_comb begin
    wr_mask  = wr_en && (sir_reg_e'(addr) == SIR_REG_MASK);
    wr_srcen = wr_en && (sir_reg_e'(addr) == SIR_REG_SRCEN);
    rd_clr   = rd_en && (sir_reg_e'(addr) == SIR_REG_STATUS);
    rd_mux   = f_read_sel(addr, status_q, mask_q, srcen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      srcen_q <= '1;
      rdata_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= wdata;
      if (wr_srcen) srcen_q <= wdata;
      if (rd_en)    rdata_q <= rd_mux;
    end
  end

  // R5: a mask write lands on the next edge
  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SIR_REG_MASK) |=> (mask_q == $past(wdata)));

  // R8: an enable write lands on the next edge
  assert_srcen_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SIR_REG_SRCEN) |=> (srcen_q == $past(wdata)));

  // R2: read data holds between read strobes
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/sir_irq_gen.sv
module sir_irq_gen #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic               cfg_mode,
  output logic               pending,
  output logic               irq_host_n,
  output logic               irq_local_n
);
  function automatic logic f_any_unmasked(
    input logic [NUM_SRC-1:0] st,
    input logic [NUM_SRC-1:0] mk
  );
    return |(st & ~mk);
  endfunction

  always_comb pending = f_any_unmasked(status_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_host_n  <= 1'b1;
      irq_local_n <= 1'b1;
    end else begin
      irq_host_n  <= ~pending;
      irq_local_n <= ~(pending & cfg_mode);
    end
  end

  // R6: an unmasked set bit pulls the host line low next cycle
  assert_host_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !irq_host_n);

  // R6: nothing unmasked, host line high
  assert_host_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> irq_host_n);

  // R7: local line stays high outside configuration mode
  assert_local_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> irq_local_n);

  // R7: local line never low while host line is high
  assert_local_implies_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_local_n |-> !irq_host_n);
endmodule

// File: rtl/sir_status_block.sv
module sir_status_block
  import sir_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_mode,
  input  logic [NUM_SRC-1:0]    evt,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [SIR_ADDR_W-1:0] addr,
  input  logic [NUM_SRC-1:0]    wdata,
  output logic [NUM_SRC-1:0]    rdata,
  output logic                  irq_host_n,
  output logic                  irq_local_n
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] srcen_q;
  logic               rd_clr;
  logic               pending;

  sir_host_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .status_q (status_q),
    .mask_q   (mask_q),
    .srcen_q  (srcen_q),
    .rd_clr   (rd_clr),
    .rdata_q  (rdata)
  );

  sir_event_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .src_en   (srcen_q),
    .rd_clr   (rd_clr),
    .status_q (status_q)
  );

  sir_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .cfg_mode    (cfg_mode),
    .pending     (pending),
    .irq_host_n  (irq_host_n),
    .irq_local_n (irq_local_n)
  );

  // R10: a write aimed at the status word changes no bit except through events or reads
  assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SIR_REG_STATUS && !rd_clr && evt == '0) |=> $stable(status_q));
endmodule

// File: tb/sim_sir_status_block.sv
module sim_sir_status_block;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_mode = 1'b0;
  logic [N-1:0] evt = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq_host_n;
  logic         irq_local_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sir_status_block #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .evt(evt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_host_n(irq_host_n), .irq_local_n(irq_local_n)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    @(negedge clk); evt = bits;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R9 rdata", rdata, '0);
    check("R9 irq_host_n", {{(N-1){1'b0}}, irq_host_n}, 1);
    check("R9 irq_local_n", {{(N-1){1'b0}}, irq_local_n}, 1);
    reg_read(2'd0, v); check("R9 status", v, '0);
    reg_read(2'd1, v); check("R5 mask reset", v, '1);
    reg_read(2'd2, v); check("R8 srcen reset", v, '1);
  endtask

  task automatic t_capture();
    logic [N-1:0] v;
    pulse(8'h05);
    repeat (3) @(negedge clk);
    pulse(8'h80);
    reg_read(2'd0, v); check("R1 sticky capture", v, 8'h85);
    reg_read(2'd0, v); check("R2 cleared after read", v, '0);
    pulse(8'hFF);
    reg_read(2'd0, v); check("R1 all bits", v, 8'hFF);
    check("R4 masked no irq", {{(N-1){1'b0}}, irq_host_n}, 1);
    reg_read(2'd0, v); check("R2 second read empty", v, '0);
  endtask

  task automatic t_collision();
    logic [N-1:0] v;
    pulse(8'h11);
    @(negedge clk); rd_en = 1'b1; addr = 2'd0; evt = 8'h22;
    @(negedge clk); rd_en = 1'b0; evt = '0;
    check("R2 read returns old bits", rdata, 8'h11);
    reg_read(2'd0, v); check("R3 collided event kept", v, 8'h22);
    reg_read(2'd0, v); check("R3 then cleared", v, '0);
  endtask

  task automatic t_mask_irq();
    logic [N-1:0] v;
    reg_write(2'd1, 8'hFB);
    reg_read(2'd1, v); check("R5 mask readback", v, 8'hFB);
    pulse(8'h01);
    @(negedge clk);
    check("R6 masked bit no irq", {{(N-1){1'b0}}, irq_host_n}, 1);
    reg_read(2'd0, v); check("R4 masked bit captured", v, 8'h01);
    pulse(8'h04);
    check("R6 not yet low", {{(N-1){1'b0}}, irq_host_n}, 1);
    @(negedge clk);
    check("R6 irq low", {{(N-1){1'b0}}, irq_host_n}, 0);
    check("R7 local high cfg off", {{(N-1){1'b0}}, irq_local_n}, 1);
    cfg_mode = 1'b1;
    @(negedge clk);
    check("R7 local low cfg on", {{(N-1){1'b0}}, irq_local_n}, 0);
    cfg_mode = 1'b0;
    @(negedge clk);
    check("R7 local high cfg off again", {{(N-1){1'b0}}, irq_local_n}, 1);
    cfg_mode = 1'b1;
    reg_read(2'd0, v); check("R2 read pending bit", v, 8'h04);
    @(negedge clk);
    check("R6 irq released", {{(N-1){1'b0}}, irq_host_n}, 1);
    check("R7 local released", {{(N-1){1'b0}}, irq_local_n}, 1);
    cfg_mode = 1'b0;
  endtask

  task automatic t_srcen();
    logic [N-1:0] v;
    reg_write(2'd2, 8'hF7);
    reg_read(2'd2, v); check("R8 srcen readback", v, 8'hF7);
    reg_write(2'd1, 8'h00);
    pulse(8'h08);
    @(negedge clk);
    check("R8 disabled no irq", {{(N-1){1'b0}}, irq_host_n}, 1);
    reg_read(2'd0, v); check("R8 disabled bit not set", v, '0);
    pulse(8'h48);
    reg_read(2'd0, v); check("R8 enabled neighbour set", v, 8'h40);
    reg_write(2'd2, 8'hFF);
    reg_write(2'd1, 8'hFF);
  endtask

  task automatic t_status_write();
    logic [N-1:0] v;
    pulse(8'h02);
    reg_write(2'd0, 8'hFF);
    reg_write(2'd0, 8'h00);
    reg_read(2'd0, v); check("R10 status write ignored", v, 8'h02);
    reg_read(2'd3, v); check("R10 unused address zero", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_collision();
    t_mask_irq();
    t_srcen();
    t_status_write();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule